// File: doc/BRIEF.md
# Vertical Reference and Drum Servo Gate Chain

This block derives the timing reference for a head-drum servo from separated vertical sync. Each vertical sync edge must pass a non-retriggerable blanking one-shot, so noise close behind a real edge is dropped. The edges that pass toggle a divide-by-two stage. This gives a square wave at half the field rate. When recording, that square wave is driven out as the control-track signal.

In playback the same divider stage is fed from a different source. It counts a mains-locked tick and makes one full period for every ten ticks, and vertical sync plays no part. In both modes the falling edge of the reference starts a delay one-shot. When the delay expires, a gate one-shot opens a window of programmable width. A signed counter runs across that window, centred on its middle, and latches its value when the head position pulse arrives. If no pulse comes, the result is the largest positive code. The result is held until the next window. The blanking, delay and gate lengths are counts of the system clock, taken from input ports.

Top module: `vref_servo_gate`

## Requirements
- R1: While rst_n is low and in the cycle after its release, ctl_o, gate_o and err_vld_o are 0 and err_o is 0.
- R2: In record mode (play_i = 0), a rising edge of vsync_i that is accepted toggles the reference, which starts at 0. The edge is the first clock at which vsync_i is sampled 1 after being 0. ctl_o shows the new level in the cycle after that clock.
- R3: Once an edge is accepted at clock E, vsync_i rising edges sampled at clocks E+1 through E+blank_len_i are ignored. An edge sampled at a later clock is accepted.
- R4: ctl_o equals the reference while play_i is 0 and is 0 while play_i is 1.
- R5: Say the reference falls from 1 to 0 at clock F, and delay_len_i is at least 1. Then gate_o is 1 for exactly gate_len_i cycles, starting in the cycle after clock F+delay_len_i, and is 0 outside that window.
- R6: Say the first pg_i rising edge of a window is sampled at clock F+delay_len_i+k, with 1 <= k <= gate_len_i. Then in the cycle after that clock, err_o equals k-1-floor(gate_len_i/2) as a signed two's-complement value, and err_vld_o is 1 for that single cycle.
- R7: If no pg_i rising edge falls inside a window, err_o becomes 2^(ERR_W-1)-1 with a one-cycle err_vld_o pulse in the cycle after the window's last clock. A pg_i edge outside a window, or a later one inside a window that has already captured, leaves err_o unchanged.
- R8: In playback mode (play_i = 1), the reference toggles on every fifth accepted rising edge of tick_i, so it completes one period per ten ticks, and vsync_i has no effect. In record mode tick_i has no effect.
- R9: A change of play_i clears the reference to 0 and clears the tick divider and all three one-shots. Edges sampled in that cycle are dropped. err_o keeps its value.
- R10: err_o holds its value in every cycle in which err_vld_o is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| play_i | input | 1 | 0 = record (sync reference), 1 = playback (tick reference) |
| vsync_i | input | 1 | Separated vertical sync, synchronous to clk |
| pg_i | input | 1 | Head position pulse, synchronous to clk |
| tick_i | input | 1 | Mains-locked tick, synchronous to clk |
| blank_len_i | input | CNT_W | Noise blanking length in clocks |
| delay_len_i | input | CNT_W | Delay from reference fall to gate start, at least 1 |
| gate_len_i | input | CNT_W | Gate window width in clocks |
| ctl_o | output | 1 | Control-track square wave (record only) |
| gate_o | output | 1 | Phase sampling window |
| err_o | output | ERR_W | Held signed phase error |
| err_vld_o | output | 1 | One-cycle pulse when err_o is updated |

## Verification
Every input passes one edge register, and every result is registered once. So ctl_o moves in the cycle after the clock that samples the accepted vsync_i edge. gate_o rises delay_len_i clocks after the falling reference clock and falls gate_len_i clocks after that. err_o and err_vld_o follow the clock that samples the pg_i edge, or the window's last clock, by one cycle. The bench drives every input on the falling clock edge and counts whole cycles from the clock that samples a stimulus. It then compares outputs on the next falling edge. Boundaries are checked on both sides: the last ignored blanking clock, the cycle before and the cycle of gate opening, and capture at the first and last window positions.

// File: rtl/vrs_pkg.sv
`timescale 1ns/1ps
package vrs_pkg;
  // ticks per reference period in playback
  localparam int PB_DIV = 10;

  // signed count value at the opening of a gate window
  function automatic int win_start(input int gate_len);
    return -(gate_len / 2);
  endfunction

  // code reported when a window closes without a head pulse
  function automatic int miss_code(input int err_w);
    return (1 << (err_w - 1)) - 1;
  endfunction
endpackage

// File: rtl/vrs_edge.sv
`timescale 1ns/1ps
module vrs_edge #(
  parameter int N = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] lvl,
  output logic [N-1:0] rise
);
  logic [N-1:0] lvl_q;

  for (genvar i = 0; i < N; i++) begin : g_bit
    always_ff @(posedge clk) begin
      if (!rst_n) lvl_q[i] <= 1'b0;
      else        lvl_q[i] <= lvl[i];
    end
    assign rise[i] = lvl[i] & ~lvl_q[i];
  end
endmodule

// File: rtl/vrs_oneshot.sv
`timescale 1ns/1ps
module vrs_oneshot #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         fire,
  input  logic [W-1:0] len,
  output logic [W-1:0] cnt
);
  // loads only from idle: a fire while counting is lost
  always_ff @(posedge clk) begin
    if (!rst_n)            cnt <= '0;
    else if (clr)          cnt <= '0;
    else if (cnt == '0) begin
      if (fire)            cnt <= len;
    end else               cnt <= cnt - 1'b1;
  end
endmodule

// File: rtl/vrs_refdiv.sv
`timescale 1ns/1ps
module vrs_refdiv #(
  parameter int DIV = vrs_pkg::PB_DIV
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic play,
  input  logic vs_evt,
  input  logic tick_evt,
  output logic ref_q,
  output logic ref_fall
);
  localparam int HALF = DIV / 2;
  localparam int DW   = $clog2(HALF + 1);

  logic [DW-1:0] tick_cnt;
  logic          pb_wrap;
  logic          flip;

  assign pb_wrap  = tick_evt && (tick_cnt == DW'(HALF - 1));
  assign flip     = !clr && (play ? pb_wrap : vs_evt);
  assign ref_fall = flip & ref_q;

  always_ff @(posedge clk) begin
    if (!rst_n || clr) begin
      tick_cnt <= '0;
      ref_q    <= 1'b0;
    end else begin
      if (play && tick_evt) tick_cnt <= pb_wrap ? '0 : tick_cnt + 1'b1;
      if (flip)             ref_q    <= ~ref_q;
    end
  end
endmodule

// File: rtl/vrs_phase.sv
`timescale 1ns/1ps
module vrs_phase #(
  parameter int CW = 16,
  parameter int EW = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 clr,
  input  logic                 start,
  input  logic [CW-1:0]        len,
  input  logic                 active,
  input  logic                 last,
  input  logic                 hit,
  output logic signed [EW-1:0] err,
  output logic                 err_vld
);
  localparam logic signed [EW-1:0] SAT = EW'(vrs_pkg::miss_code(EW));

  logic signed [EW-1:0] ph;
  logic                 got;
  logic                 cap;
  logic                 miss;

  assign cap  = active && hit && !got && !clr;
  assign miss = active && last && !got && !hit && !clr;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ph      <= '0;
      got     <= 1'b0;
      err     <= '0;
      err_vld <= 1'b0;
    end else begin
      if (start) begin
        ph  <= EW'(vrs_pkg::win_start(int'(len)));
        got <= 1'b0;
      end else if (active && ph != SAT) begin
        ph  <= ph + 1'b1;
      end
      if (cap) got <= 1'b1;
      if (cap)       err <= ph;
      else if (miss) err <= SAT;
      err_vld <= cap | miss;
    end
  end
endmodule

// File: rtl/vref_servo_gate.sv
`timescale 1ns/1ps
module vref_servo_gate #(
  parameter int CNT_W  = 16,
  parameter int ERR_W  = 16,
  parameter int PB_DIV = vrs_pkg::PB_DIV
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    play_i,
  input  logic                    vsync_i,
  input  logic                    pg_i,
  input  logic                    tick_i,
  input  logic [CNT_W-1:0]        blank_len_i,
  input  logic [CNT_W-1:0]        delay_len_i,
  input  logic [CNT_W-1:0]        gate_len_i,
  output logic                    ctl_o,
  output logic                    gate_o,
  output logic signed [ERR_W-1:0] err_o,
  output logic                    err_vld_o
);
  localparam int NOS = 3;            // blank, delay, gate
  localparam int OS_BLANK = 0;
  localparam int OS_DELAY = 1;
  localparam int OS_GATE  = 2;

  logic             play_q;
  logic             mode_chg;
  logic [2:0]       rise;
  logic             vs_rise, pg_rise, tick_evt;
  logic             blank_busy, vs_take;
  logic             ref_q, ref_fall;
  logic             dly_busy, dly_last;
  logic             gate_busy, gate_last, gate_take;
  logic [NOS-1:0]   os_fire;
  logic [CNT_W-1:0] os_len [NOS];
  logic [CNT_W-1:0] os_cnt [NOS];

  always_ff @(posedge clk) begin
    if (!rst_n) play_q <= 1'b0;
    else        play_q <= play_i;
  end
  assign mode_chg = play_i ^ play_q;

  vrs_edge #(.N(3)) u_edge (
    .clk(clk), .rst_n(rst_n),
    .lvl({tick_i, pg_i, vsync_i}), .rise(rise)
  );
  assign vs_rise  = rise[0];
  assign pg_rise  = rise[1];
  assign tick_evt = rise[2];

  assign os_len[OS_BLANK] = blank_len_i;
  assign os_len[OS_DELAY] = delay_len_i;
  assign os_len[OS_GATE]  = gate_len_i;
  assign os_fire = {dly_last, ref_fall, vs_rise};

  for (genvar i = 0; i < NOS; i++) begin : g_os
    vrs_oneshot #(.W(CNT_W)) u_os (
      .clk(clk), .rst_n(rst_n), .clr(mode_chg),
      .fire(os_fire[i]), .len(os_len[i]), .cnt(os_cnt[i])
    );
  end

  assign blank_busy = (os_cnt[OS_BLANK] != '0);
  assign vs_take    = vs_rise && !blank_busy && !mode_chg;
  assign dly_busy   = (os_cnt[OS_DELAY] != '0);
  assign dly_last   = (os_cnt[OS_DELAY] == CNT_W'(1));
  assign gate_busy  = (os_cnt[OS_GATE] != '0);
  assign gate_last  = (os_cnt[OS_GATE] == CNT_W'(1));
  assign gate_take  = dly_last && !gate_busy && !mode_chg;

  vrs_refdiv #(.DIV(PB_DIV)) u_ref (
    .clk(clk), .rst_n(rst_n), .clr(mode_chg), .play(play_i),
    .vs_evt(vs_take), .tick_evt(tick_evt),
    .ref_q(ref_q), .ref_fall(ref_fall)
  );

  vrs_phase #(.CW(CNT_W), .EW(ERR_W)) u_phase (
    .clk(clk), .rst_n(rst_n), .clr(mode_chg),
    .start(gate_take), .len(gate_len_i),
    .active(gate_busy), .last(gate_last), .hit(pg_rise),
    .err(err_o), .err_vld(err_vld_o)
  );

  assign ctl_o  = ref_q & ~play_i;
  assign gate_o = gate_busy;
endmodule

// File: rtl/vref_servo_chk.sv
`timescale 1ns/1ps
module vref_servo_chk #(
  parameter int ERR_W = 16
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    play_i,
  input logic                    mode_chg,
  input logic                    blank_busy,
  input logic                    tick_evt,
  input logic                    ref_q,
  input logic                    dly_busy,
  input logic                    ctl_o,
  input logic                    gate_o,
  input logic signed [ERR_W-1:0] err_o,
  input logic                    err_vld_o
);
  a_r3_blank_holds_ref: assert property (@(posedge clk) disable iff (!rst_n)
    (!play_i && blank_busy && !mode_chg) |=> $stable(ref_q));

  a_r8_tick_only_moves_ref: assert property (@(posedge clk) disable iff (!rst_n)
    (play_i && !tick_evt && !mode_chg) |=> $stable(ref_q));

  a_r4_ctl_quiet_in_play: assert property (@(posedge clk) disable iff (!rst_n)
    play_i |-> !ctl_o);

  a_r5_gate_follows_delay: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(gate_o) |-> $past(dly_busy));

  a_r6_valid_single: assert property (@(posedge clk) disable iff (!rst_n)
    err_vld_o |=> !err_vld_o);

  a_r10_err_held: assert property (@(posedge clk) disable iff (!rst_n)
    !err_vld_o |-> $stable(err_o));

  a_r9_mode_clears: assert property (@(posedge clk) disable iff (!rst_n)
    mode_chg |=> (!gate_o && !ref_q));
endmodule

bind vref_servo_gate vref_servo_chk #(.ERR_W(ERR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .play_i(play_i), .mode_chg(mode_chg),
  .blank_busy(blank_busy), .tick_evt(tick_evt), .ref_q(ref_q),
  .dly_busy(dly_busy), .ctl_o(ctl_o), .gate_o(gate_o),
  .err_o(err_o), .err_vld_o(err_vld_o)
);

// File: tb/tb_vref_servo_gate.sv
`timescale 1ns/1ps
module tb_vref_servo_gate;
  localparam int CNT_W = 16;
  localparam int ERR_W = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic play_i = 1'b0, vsync_i = 1'b0, pg_i = 1'b0, tick_i = 1'b0;
  logic [CNT_W-1:0] blank_len_i, delay_len_i, gate_len_i;
  logic ctl_o, gate_o, err_vld_o;
  logic signed [ERR_W-1:0] err_o;

  int total = 0;
  int bad = 0;
  bit done = 0;
  int L, D, G;

  always #2.5 clk = ~clk;

  vref_servo_gate #(.CNT_W(CNT_W), .ERR_W(ERR_W)) dut (
    .clk(clk), .rst_n(rst_n), .play_i(play_i), .vsync_i(vsync_i),
    .pg_i(pg_i), .tick_i(tick_i), .blank_len_i(blank_len_i),
    .delay_len_i(delay_len_i), .gate_len_i(gate_len_i),
    .ctl_o(ctl_o), .gate_o(gate_o), .err_o(err_o), .err_vld_o(err_vld_o)
  );

  // expected capture value: position k inside a window of width g
  function automatic int hit_val(input int g, input int k);
    int half;
    half = g >> 1;
    return (k - 1) - half;
  endfunction

  function automatic int sat_val();
    return 32'h7FFF_FFFF >>> (32 - ERR_W);
  endfunction

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_vs();
    vsync_i = 1'b1; step(1); vsync_i = 1'b0;
  endtask

  task automatic pulse_pg();
    pg_i = 1'b1; step(1); pg_i = 1'b0;
  endtask

  task automatic pulse_tick();
    tick_i = 1'b1; step(1); tick_i = 1'b0;
  endtask

  // one record-mode frame pair: k=0 means no head pulse in the window
  task automatic record_round(input int k, input bit boundary);
    int held;
    step(L + 1);
    pulse_vs();
    check("R2 rise sets ctl", int'(ctl_o), 1);
    if (boundary) begin
      step(L - 1);
      pulse_vs();                       // sampled at E+L: inside blanking
      check("R3 edge at last blank clock ignored", int'(ctl_o), 1);
      step(1);                          // sampled at E+L+2: accepted
    end else begin
      step(L);
    end
    pulse_vs();                         // falling reference at clock F
    check("R2 fall clears ctl", int'(ctl_o), 0);
    if (k == 0) begin
      pg_i = 1'b1; step(1); pg_i = 1'b0; // during the delay: ignored
      step(D - 2);
    end else begin
      step(D - 1);
    end
    check("R5 gate closed before delay end", int'(gate_o), 0);
    step(1);
    check("R5 gate open after delay", int'(gate_o), 1);
    if (k == 0) begin
      step(G - 1);
      check("R5 gate still open on last cycle", int'(gate_o), 1);
      step(1);
      check("R5 gate closed after width", int'(gate_o), 0);
      check("R7 miss code", int'(err_o), sat_val());
      check("R7 miss valid pulse", int'(err_vld_o), 1);
      pulse_pg();                       // outside any window
      check("R7 late pulse ignored", int'(err_o), sat_val());
    end else begin
      step(k - 1);
      pulse_pg();
      check("R6 captured phase", int'(err_o), hit_val(G, k));
      check("R6 valid pulse", int'(err_vld_o), 1);
      held = int'(err_o);
      step(1);
      check("R6 valid one cycle", int'(err_vld_o), 0);
      if (k + 2 <= G) begin
        pulse_pg();                     // second pulse in same window
        check("R7 second pulse ignored", int'(err_o), held);
        check("R7 second pulse no valid", int'(err_vld_o), 0);
      end
      step(G + 2);
      check("R10 error held after window", int'(err_o), held);
      check("R5 gate closed after window", int'(gate_o), 0);
    end
  endtask

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      bad++;
      total++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int held;
    void'($urandom(32'd2917));
    L = $urandom_range(3, 10);
    D = $urandom_range(2, 12);
    G = $urandom_range(3, 20);
    blank_len_i = CNT_W'(L);
    delay_len_i = CNT_W'(D);
    gate_len_i  = CNT_W'(G);

    step(3);
    check("R1 reset ctl", int'(ctl_o), 0);
    check("R1 reset gate", int'(gate_o), 0);
    check("R1 reset err", int'(err_o), 0);
    rst_n = 1'b1;
    step(1);
    check("R1 released valid", int'(err_vld_o), 0);
    check("R1 released err", int'(err_o), 0);

    // directed corners, then constrained random positions
    record_round(1, 1'b1);
    record_round(G, 1'b0);
    record_round(0, 1'b0);
    for (int r = 0; r < 8; r++) begin
      record_round($urandom_range(0, G), 1'b0);
    end

    // playback: ticks drive the reference, sync does nothing (R8)
    step(L + 2);
    play_i = 1'b1;
    step(1);
    check("R4 ctl quiet in playback", int'(ctl_o), 0);
    step(2);
    for (int t = 1; t <= 9; t++) begin
      pulse_tick();
      step(1);
      pulse_vs();
      step(1);
    end
    step(D + 2);
    check("R8 no gate before tenth tick", int'(gate_o), 0);
    pulse_tick();                       // tenth tick: reference falls
    step(D - 1);
    check("R8 gate closed before delay end", int'(gate_o), 0);
    step(1);
    check("R8 gate after tenth tick", int'(gate_o), 1);
    pulse_pg();
    check("R8 playback capture", int'(err_o), hit_val(G, 1));
    held = int'(err_o);

    // leave playback with the window open (R9)
    play_i = 1'b0;
    step(1);
    check("R9 gate cut by mode change", int'(gate_o), 0);
    check("R9 reference cleared", int'(ctl_o), 0);
    check("R9 error retained", int'(err_o), held);
    step(G + 2);
    check("R9 no partial gate", int'(gate_o), 0);
    pulse_vs();
    check("R9 divider restarts from zero", int'(ctl_o), 1);
    step(L + 1);
    for (int t = 0; t < 6; t++) begin
      pulse_tick();
      step(1);
    end
    check("R8 ticks ignored in record", int'(ctl_o), 1);
    check("R8 ticks open no gate", int'(gate_o), 0);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule